// File: doc/BRIEF.md
# Flash Write-Status Readback Generator

This block produces the status byte that a parallel NOR flash returns while an internal byte program or erase is in flight. A single-cycle start strobe names the operation (byte program, sector erase or chip erase) and, for a program, the byte to be written together with the current array byte at the target. From the clock edge that accepts the start, the block holds a busy flag for a fixed number of clock cycles chosen per operation type by parameters.

While busy, every read strobe is answered with a status byte instead of array data. The top data bit is a polling bit: the inverse of the pending byte's top bit during a program, zero during an erase. The next bit flips on every read. The remaining low bits carry the array byte unchanged. Once the count expires, busy drops, a one-cycle commit pulse reports the byte value the array now holds, and reads return array data again. Command decoding, array storage and analog timing belong to neighbouring logic.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, `busy_o`, `rd_valid_o` and `commit_o` are 0.
- R2: The operation code on `op_i` is 1 = byte program, 2 = sector erase, 3 = chip erase. An accepted start raises `busy_o` from the next cycle for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles. A start with code 0 is ignored and leaves `busy_o` at 0.
- R3: For a read strobe taken while a program is busy, bit DW-1 of the returned byte is the inverse of bit DW-1 of the pending program byte.
- R4: For a read strobe taken while an erase is busy, bit DW-1 of the returned byte is 0.
- R5: Bit DW-2 of the status byte is 0 on the first busy read after a start. It inverts on each further busy read and holds its value between reads.
- R6: In the status byte, bits DW-3 down to 0 equal the same bits of `arr_data_i` in the strobe cycle.
- R7: A read strobe in a cycle with `busy_o` at 0 returns `arr_data_i` unchanged. Every read result appears on `rd_data_o` with `rd_valid_o` high in the cycle after the strobe.
- R8: A start in a cycle with `busy_o` high is ignored. The running length, the operation kind and the pending byte stay as they were.
- R9: In the first cycle with `busy_o` back at 0, `commit_o` is high for exactly one cycle. `commit_kind_o` then equals the operation code, and `commit_data_o` equals the old byte AND the program byte for a program, or all ones for an erase.
- R10: A read strobe in the cycle that carries the accepted start returns array data. A read strobe in the last busy cycle still returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for an internal operation |
| op_i | input | 2 | Operation code: 1 program, 2 sector erase, 3 chip erase |
| pgm_data_i | input | DW | Byte to be programmed (sampled with the start) |
| rd_i | input | 1 | Read strobe |
| arr_data_i | input | DW | Array byte at the current address. Also taken as the old byte for a program start |
| rd_data_o | output | DW | Read result, status or array data |
| rd_valid_o | output | 1 | Read result valid, one cycle after `rd_i` |
| busy_o | output | 1 | Internal operation in progress |
| commit_o | output | 1 | One-cycle pulse when the operation ends |
| commit_kind_o | output | 2 | Operation code of the ended operation |
| commit_data_o | output | DW | Resulting array byte of the ended operation |

## Verification
Two functions can land in the same cycle: a read strobe and a change of the busy state. A read can coincide with the edge that accepts a start, and a read can fall in the last busy cycle, the edge where completion and commit happen. The bench provokes both by reading in every cycle across each operation, including the start cycle and the cycle after busy falls. It judges each result by the value of `busy_o` it saw in the strobe cycle: status if busy was high, raw array data if not. A stray start issued mid-operation lands in the same cycle as busy reads, so it also has to leave the toggle sequence, the polling bit and the length untouched.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } fws_op_e;

  function automatic logic op_is_erase(fws_op_e op);
    return (op == OP_SECT) || (op == OP_CHIP);
  endfunction

  // polling bit shown while busy: inverse of pending MSB for a program, 0 for erase
  function automatic logic poll_bit(fws_op_e op, logic pend_msb);
    return (op == OP_PROG) ? ~pend_msb : 1'b0;
  endfunction

  // program can only clear bits
  function automatic logic [63:0] prog_merge(logic [63:0] old_b, logic [63:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/fws_busy_timer.sv
module fws_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          busy,
  output logic          fin,
  output logic [CW-1:0] cnt
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= load_len;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign fin  = busy_q && (cnt_q == CW'(1));
  assign cnt  = cnt_q;

endmodule

// File: rtl/fws_toggle.sv
module fws_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);

  logic q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)   q_r <= 1'b0;
    else if (clr) q_r <= 1'b0;
    else if (adv) q_r <= ~q_r;
  end

  assign q = q_r;

endmodule

// File: rtl/fws_read_path.sv
module fws_read_path
  import fws_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          busy,
  input  fws_op_e       op,
  input  logic          pend_msb,
  input  logic          tog,
  input  logic [DW-1:0] arr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int LOW_W = DW - 2;

  logic [DW-1:0] status_b;
  logic [DW-1:0] next_b;
  logic [DW-1:0] data_q;
  logic          valid_q;

  assign status_b[DW-1] = poll_bit(op, pend_msb);
  assign status_b[DW-2] = tog;

  genvar gi;
  generate
    for (gi = 0; gi < LOW_W; gi++) begin : g_low
      assign status_b[gi] = arr[gi];
    end
  endgenerate

  assign next_b = busy ? status_b : arr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd;
      if (rd) data_q <= next_b;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import fws_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PROG_CYC = 5,
  parameter int SECT_CYC = 40,
  parameter int CHIP_CYC = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] pgm_data_i,
  input  logic          rd_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          busy_o,
  output logic          commit_o,
  output logic [1:0]    commit_kind_o,
  output logic [DW-1:0] commit_data_o
);

  localparam int MAX_A  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_LEN = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CW     = $clog2(MAX_LEN + 1);

  function automatic logic [CW-1:0] len_of(fws_op_e o);
    case (o)
      OP_PROG: return CW'(PROG_CYC);
      OP_SECT: return CW'(SECT_CYC);
      default: return CW'(CHIP_CYC);
    endcase
  endfunction

  // named internal events
  fws_op_e       op_in;
  logic          accept;
  logic          fin;
  logic          busy;
  logic          tog;
  logic          rd_busy;
  logic [CW-1:0] cnt;
  fws_op_e       op_q;
  logic [DW-1:0] pend_q;
  logic [DW-1:0] old_q;
  logic [63:0]   merged;

  assign op_in   = fws_op_e'(op_i);
  assign accept  = start_i && !busy && (op_in != OP_NONE);
  assign rd_busy = rd_i && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      pend_q <= '0;
      old_q  <= '0;
    end else if (accept) begin
      op_q   <= op_in;
      pend_q <= pgm_data_i;
      old_q  <= arr_data_i;
    end
  end

  fws_busy_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_len (len_of(op_in)),
    .busy     (busy),
    .fin      (fin),
    .cnt      (cnt)
  );

  fws_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .adv   (rd_busy),
    .q     (tog)
  );

  fws_read_path #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (rd_i),
    .busy     (busy),
    .op       (op_q),
    .pend_msb (pend_q[DW-1]),
    .tog      (tog),
    .arr      (arr_data_i),
    .rd_data  (rd_data_o),
    .rd_valid (rd_valid_o)
  );

  assign merged = prog_merge(64'(old_q), 64'(pend_q));

  logic          commit_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] cdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      kind_q   <= 2'd0;
      cdata_q  <= '0;
    end else begin
      commit_q <= fin;
      if (fin) begin
        kind_q  <= op_q;
        cdata_q <= op_is_erase(op_q) ? {DW{1'b1}} : merged[DW-1:0];
      end
    end
  end

  assign busy_o        = busy;
  assign commit_o      = commit_q;
  assign commit_kind_o = kind_q;
  assign commit_data_o = cdata_q;

endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_i,
  input logic [DW-1:0] arr_data_i,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_valid_o,
  input logic          busy_o,
  input logic          commit_o,
  input logic          accept,
  input logic          tog,
  input logic [1:0]    op_q,
  input logic [DW-1:0] pend_q
);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(busy_o) && $past(op_q) == 2'd1)
      |-> rd_data_o[DW-1] == !$past(pend_q[DW-1]));

  assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(busy_o) && $past(op_q) != 2'd1) |-> !rd_data_o[DW-1]);

  assert_tog_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tog);

  assert_tog_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && busy_o) |=> tog != $past(tog));

  assert_tog_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !accept) |=> $stable(tog));

  assert_idle_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !$past(busy_o)) |-> rd_data_o == $past(arr_data_i));

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept);

  assert_fall_commits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> commit_o);

  assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

endmodule

bind flash_wstat_gen fws_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_i       (rd_i),
  .arr_data_i (arr_data_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .busy_o     (busy_o),
  .commit_o   (commit_o),
  .accept     (accept),
  .tog        (tog),
  .op_q       (op_q),
  .pend_q     (pend_q)
);

// File: tb/tb_flash_wstat_gen.sv
module tb_flash_wstat_gen;

  localparam int DW = 8;
  localparam int PC = 5;
  localparam int SC = 40;
  localparam int CC = 150;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic [DW-1:0] pgm_data_i = '0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] arr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o;
  logic          busy_o;
  logic          commit_o;
  logic [1:0]    commit_kind_o;
  logic [DW-1:0] commit_data_o;

  int checks = 0;
  int errors = 0;

  // read tracking
  bit            pend_rd = 0;
  bit            pend_busy = 0;
  logic [DW-1:0] exp_rd = '0;
  string         pend_tag = "";

  always #2 clk = ~clk;

  flash_wstat_gen #(.DW(DW), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .pgm_data_i(pgm_data_i),
    .rd_i(rd_i), .arr_data_i(arr_data_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .busy_o(busy_o), .commit_o(commit_o), .commit_kind_o(commit_kind_o),
    .commit_data_o(commit_data_o));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  // checks the read issued in the previous cycle, called at a negedge
  task automatic check_read();
    if (pend_rd) begin
      chk(rd_valid_o == 1'b1, "R7 valid", 32'(rd_valid_o), 1);
      if (pend_busy) begin
        chk(rd_data_o[7] == exp_rd[7], (exp_rd[7] === 1'b0 && pend_tag == "E") ? "R4 poll" : "R3 poll",
            32'(rd_data_o[7]), 32'(exp_rd[7]));
        chk(rd_data_o[6] == exp_rd[6], "R5 toggle", 32'(rd_data_o[6]), 32'(exp_rd[6]));
        chk(rd_data_o[5:0] == exp_rd[5:0], "R6 low bits", 32'(rd_data_o[5:0]), 32'(exp_rd[5:0]));
      end else begin
        chk(rd_data_o == exp_rd, (pend_tag == "S") ? "R10 start-cycle read" : "R7 idle read",
            32'(rd_data_o), 32'(exp_rd));
      end
    end else begin
      chk(rd_valid_o == 1'b0, "R7 no valid", 32'(rd_valid_o), 0);
    end
    pend_rd = 0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [7:0] pd, input logic [7:0] old, input int mode);
    int  len;
    int  busy_cnt;
    bit  ended;
    bit  tog_exp;
    bit  was_busy;
    len = (op == 2'd1) ? PC : (op == 2'd2) ? SC : CC;
    busy_cnt = 0;
    ended = 0;
    tog_exp = 0;
    was_busy = 0;
    @(negedge clk);
    check_read();
    start_i = 1'b1; op_i = op; pgm_data_i = pd; arr_data_i = old;
    rd_i = 1'b1;                      // read in the start cycle: R10
    pend_rd = 1; pend_busy = 0; exp_rd = old; pend_tag = "S";
    for (int k = 0; k < len + 3; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      check_read();
      if (!busy_o && !ended) begin
        ended = 1;
        chk(busy_cnt == len, "R2 busy length", 32'(busy_cnt), 32'(len));
        chk(commit_o == 1'b1, "R9 commit pulse", 32'(commit_o), 1);
        chk(commit_kind_o == op, "R9 commit kind", 32'(commit_kind_o), 32'(op));
        chk(commit_data_o == ((op == 2'd1) ? (old & pd) : 8'hFF), "R9 commit data",
            32'(commit_data_o), 32'((op == 2'd1) ? (old & pd) : 8'hFF));
      end else begin
        chk(commit_o == 1'b0, "R9 commit quiet", 32'(commit_o), 0);
      end
      if (busy_o) begin
        busy_cnt++;
        if (ended) chk(1'b0, "R8 busy restarted", 1, 0);
      end
      was_busy = busy_o;
      rd_i = (mode == 0) ? 1'b1 : ((k % 3) == 0);
      arr_data_i = 8'((k * 37 + 11) ^ pd);
      // stray start while busy must be ignored: R8
      if (mode == 1 && busy_o && k == 2) begin
        start_i = 1'b1; op_i = (op == 2'd1) ? 2'd3 : 2'd1; pgm_data_i = ~pd;
      end
      if (rd_i) begin
        pend_rd = 1;
        pend_busy = was_busy;
        pend_tag = (op == 2'd1) ? "P" : "E";
        if (was_busy) begin
          exp_rd = {((op == 2'd1) ? ~pd[7] : 1'b0), tog_exp, arr_data_i[5:0]};
          tog_exp = ~tog_exp;
        end else begin
          exp_rd = arr_data_i;
          pend_tag = "I";
        end
      end
    end
    @(negedge clk);
    rd_i = 1'b0; start_i = 1'b0;
    check_read();
    chk(ended == 1'b1, "R2 operation ended", 32'(ended), 1);
  endtask

  initial begin
    logic [7:0] pds  [5];
    logic [7:0] olds [2];
    pds[0] = 8'h00; pds[1] = 8'h80; pds[2] = 8'h7F; pds[3] = 8'hFF; pds[4] = 8'hA5;
    olds[0] = 8'hFF; olds[1] = 8'h3C;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy at reset", 32'(busy_o), 0);
    chk(rd_valid_o == 1'b0, "R1 valid at reset", 32'(rd_valid_o), 0);
    chk(commit_o == 1'b0, "R1 commit at reset", 32'(commit_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // code 0 start is ignored: R2
    start_i = 1'b1; op_i = 2'd0; pgm_data_i = 8'h12;
    rd_i = 1'b1; arr_data_i = 8'h5A;
    @(negedge clk);
    start_i = 1'b0; rd_i = 1'b0;
    chk(busy_o == 1'b0, "R2 null op ignored", 32'(busy_o), 0);
    chk(rd_data_o == 8'h5A, "R7 null-op read", 32'(rd_data_o), 32'h5A);
    for (int op = 1; op <= 3; op++)
      for (int p = 0; p < 5; p++)
        for (int o = 0; o < 2; o++)
          for (int m = 0; m < 2; m++)
            run_op(2'(op), pds[p], olds[o], m);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule